// File: doc/BRIEF.md
# Phased-Write Pseudo Dual-Port RAM

This block gives one synchronous read port and one write port with separate address and data buses. It is built from two single-port storage banks, each able to do either one read or one write per cycle. Both banks hold a complete copy of the contents. A free-running one-bit phase divides time into alternating write slots and commit slots. Which parity is the write slot is chosen by the parameter `WR_PHASE`.

A write is accepted only when `wr_en` is high in a write slot. The lead bank takes the data at that clock edge. A holding register keeps the address and data, and the trail bank takes them at the following edge. The read is steered to the bank that is idle in that cycle: the trail bank in a write slot, the lead bank in a commit slot. The read port is therefore never blocked.

With `TRANSPARENT=1`, a read and an accepted write to the same address in the same cycle return the new data through a bypass register. With `TRANSPARENT=0`, that read returns the old contents. Each bank has a combinational peek port for verification.

Top module: `pdp_phased_ram`

## Requirements
- R1: While `rst_n` is low, `rd_data` is zero and the phase counter is held at its start value.
- R2: `wr_slot` alternates between high and low on every clock after reset. A write is accepted exactly when `wr_en` is high in a cycle where `wr_slot` is high.
- R3: A write presented with `wr_slot` low changes no stored word; later reads of that address return the previous contents.
- R4: `rd_data` in the cycle after `rd_addr` is presented holds the word stored at that address before that clock edge, except in the same-address case of R6.
- R5: With `TRANSPARENT=0`, a read and an accepted write to the same address in the same cycle return the old stored word.
- R6: With `TRANSPARENT=1`, a read and an accepted write to the same address in the same cycle return the written data one cycle later.
- R7: A read in the cycle right after an accepted write, of that same address, returns the newly written data while the trail bank's update is still pending.
- R8: The lead bank holds an accepted word after the accepting edge and the trail bank after the next edge. Never do both banks write in one cycle, and never does one bank read and write in one cycle.
- R9: With `WR_PHASE=0` the first cycle after reset is a write slot; with `WR_PHASE=1` the second is.
- R10: `dbg_lead_data` and `dbg_trail_data` follow `dbg_addr` combinationally, in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write request, honoured only in a write slot |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| wr_slot | output | 1 | High in cycles where a write can be accepted |
| rd_addr | input | ADDR_W | Read address, sampled every cycle |
| rd_data | output | DATA_W | Read data, one cycle after the address |
| dbg_addr | input | ADDR_W | Peek address for both banks |
| dbg_lead_data | output | DATA_W | Lead bank word at `dbg_addr`, combinational |
| dbg_trail_data | output | DATA_W | Trail bank word at `dbg_addr`, combinational |

## Verification
Read data is due one clock after the address. The reference model computes the expected word at the capturing edge and compares it half a cycle later, before the next edge can move it. The lead bank's peek must show an accepted write right after the accepting edge, and the trail bank's peek one edge later. The bench therefore keeps two model arrays that are updated on those two edges and compares both peeks on every cycle. The peek compare is made one time unit after `dbg_addr` moves at the falling edge, so no clock edge separates the address change from the compare. Two instances share the stimulus, one transparent with even write slots and one non-transparent with odd write slots, so every cycle is a write slot for exactly one of them.

// File: rtl/pdp_pkg.sv
package pdp_pkg;
  localparam int unsigned NUM_BANKS = 2;

  typedef enum logic {
    BANK_LEAD  = 1'b0,
    BANK_TRAIL = 1'b1
  } bank_role_e;
endpackage

// File: rtl/pdp_phase.sv
module pdp_phase #(
  parameter bit WR_PHASE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  output logic slot
);
  logic phase_q;
  logic phase_d;

  always_comb begin
    phase_d = ~phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase_d;
  end

  assign slot = (phase_q == WR_PHASE);

  AST_SLOT_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    slot |=> !slot); // R2
  AST_SLOT_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    !slot |=> slot); // R2
endmodule

// File: rtl/pdp_bank.sv
module pdp_bank #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [ADDR_W-1:0] peek0_addr,
  output logic [DATA_W-1:0] peek0_data,
  input  logic [ADDR_W-1:0] peek1_addr,
  output logic [DATA_W-1:0] peek1_data
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rdata_d;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (re) rdata_d = mem[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata      = rdata_q;
  assign peek0_data = mem[peek0_addr];
  assign peek1_data = mem[peek1_addr];

  AST_SINGLE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && re)); // R8
endmodule

// File: rtl/pdp_hold.sv
module pdp_hold #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  logic              valid_q, valid_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    valid_d = load;
    addr_d  = addr_q;
    data_d  = data_q;
    if (load) begin
      addr_d = addr_in;
      data_d = data_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    addr_q <= addr_d;
    data_q <= data_d;
  end

  assign valid = valid_q;
  assign addr  = addr_q;
  assign data  = data_q;

  AST_HOLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q); // R8
endmodule

// File: rtl/pdp_phased_ram.sv
module pdp_phased_ram #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 4,
  parameter bit          WR_PHASE    = 1'b0,
  parameter bit          TRANSPARENT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_slot,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [ADDR_W-1:0] dbg_addr,
  output logic [DATA_W-1:0] dbg_lead_data,
  output logic [DATA_W-1:0] dbg_trail_data
);
  import pdp_pkg::*;

  logic              slot;
  logic              wr_acc;
  logic              hold_valid;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_data;

  logic              bank_we   [NUM_BANKS];
  logic              bank_re   [NUM_BANKS];
  logic [ADDR_W-1:0] bank_addr [NUM_BANKS];
  logic [DATA_W-1:0] bank_wdat [NUM_BANKS];
  logic [DATA_W-1:0] bank_rdat [NUM_BANKS];
  logic [DATA_W-1:0] bank_dbg  [NUM_BANKS];
  logic [DATA_W-1:0] bank_chk  [NUM_BANKS];

  bank_role_e        rd_src_q, rd_src_d;
  logic              byp_hit;
  logic [DATA_W-1:0] byp_data;

  pdp_phase #(.WR_PHASE(WR_PHASE)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .slot  (slot)
  );

  assign wr_slot = slot;
  assign wr_acc  = wr_en && slot;

  pdp_hold #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (wr_acc),
    .addr_in (wr_addr),
    .data_in (wr_data),
    .valid   (hold_valid),
    .addr    (hold_addr),
    .data    (hold_data)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    if (b == int'(BANK_LEAD)) begin : g_lead
      always_comb begin
        bank_we[b]   = wr_acc;
        bank_re[b]   = !slot;
        bank_addr[b] = slot ? wr_addr : rd_addr;
        bank_wdat[b] = wr_data;
      end
    end else begin : g_trail
      always_comb begin
        bank_we[b]   = hold_valid;
        bank_re[b]   = slot;
        bank_addr[b] = hold_valid ? hold_addr : rd_addr;
        bank_wdat[b] = hold_data;
      end
    end

    pdp_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (bank_we[b]),
      .re         (bank_re[b]),
      .addr       (bank_addr[b]),
      .wdata      (bank_wdat[b]),
      .rdata      (bank_rdat[b]),
      .peek0_addr (dbg_addr),
      .peek0_data (bank_dbg[b]),
      .peek1_addr (hold_addr),
      .peek1_data (bank_chk[b])
    );
  end

  assign dbg_lead_data  = bank_dbg[BANK_LEAD];
  assign dbg_trail_data = bank_dbg[BANK_TRAIL];

  always_comb begin
    rd_src_d = slot ? BANK_TRAIL : BANK_LEAD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_src_q <= BANK_LEAD;
    else        rd_src_q <= rd_src_d;
  end

  if (TRANSPARENT) begin : g_bypass
    logic              byp_q, byp_d;
    logic [DATA_W-1:0] bypd_q, bypd_d;

    always_comb begin
      byp_d  = wr_acc && (rd_addr == wr_addr);
      bypd_d = bypd_q;
      if (byp_d) bypd_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byp_q <= 1'b0;
      else        byp_q <= byp_d;
    end

    always_ff @(posedge clk) begin
      bypd_q <= bypd_d;
    end

    assign byp_hit  = byp_q;
    assign byp_data = bypd_q;

    AST_FORWARD_NEW: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_slot && rd_addr == wr_addr) |=> rd_data == $past(wr_data)); // R6
  end else begin : g_no_bypass
    assign byp_hit  = 1'b0;
    assign byp_data = '0;
  end

  assign rd_data = byp_hit ? byp_data : bank_rdat[rd_src_q];

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    !(bank_we[0] && bank_we[1])); // R8
  AST_HOLD_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    hold_valid |-> bank_chk[BANK_LEAD] == hold_data); // R8
  AST_TRAIL_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    hold_valid |=> bank_chk[BANK_TRAIL] == $past(hold_data)); // R8
  AST_HOLD_OFF_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    hold_valid |-> !wr_slot); // R2
endmodule

// File: tb/pdp_phased_ram_test.sv
module pdp_phased_ram_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [AW-1:0] dbg_addr = '0;
  logic          started = 1'b0;

  logic          slot_o  [2];
  logic [DW-1:0] rd_o    [2];
  logic [DW-1:0] lead_o  [2];
  logic [DW-1:0] trail_o [2];

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  // instance 0: transparent, even write slots; instance 1: non-transparent, odd
  function automatic bit wp(int k); return k[0]; endfunction
  function automatic bit tr(int k); return k == 0; endfunction

  pdp_phased_ram #(.DATA_W(DW), .ADDR_W(AW), .WR_PHASE(1'b0), .TRANSPARENT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_slot(slot_o[0]), .rd_addr(rd_addr), .rd_data(rd_o[0]), .dbg_addr(dbg_addr),
    .dbg_lead_data(lead_o[0]), .dbg_trail_data(trail_o[0]));

  pdp_phased_ram #(.DATA_W(DW), .ADDR_W(AW), .WR_PHASE(1'b1), .TRANSPARENT(1'b0)) uut_nt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_slot(slot_o[1]), .rd_addr(rd_addr), .rd_data(rd_o[1]), .dbg_addr(dbg_addr),
    .dbg_lead_data(lead_o[1]), .dbg_trail_data(trail_o[1]));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state
  logic [DW-1:0] m_lead  [2][DEPTH];
  logic [DW-1:0] m_trail [2][DEPTH];
  logic [DW-1:0] exp_rd  [2] = '{default: '0};
  string         rd_tag  [2] = '{default: "R1"};
  bit            pend_v  [2] = '{default: 1'b0};
  logic [AW-1:0] pend_a  [2];
  logic [DW-1:0] pend_d  [2];
  bit            prev_acc[2] = '{default: 1'b0};
  logic [AW-1:0] prev_a  [2];
  bit            ign_v   [2] = '{default: 1'b0};
  logic [AW-1:0] ign_a   [2];

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, expv, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < 2; k++) begin
        bit acc;
        acc = wr_en && ((cyc % 2) == int'(wp(k)));
        if (acc && rd_addr == wr_addr) begin
          exp_rd[k] = tr(k) ? wr_data : m_lead[k][rd_addr];
          rd_tag[k] = tr(k) ? "R6" : "R5";
        end else begin
          exp_rd[k] = m_lead[k][rd_addr];
          if (prev_acc[k] && prev_a[k] == rd_addr) rd_tag[k] = "R7";
          else if (ign_v[k] && ign_a[k] == rd_addr) rd_tag[k] = "R3";
          else rd_tag[k] = "R4";
        end
        if (pend_v[k]) m_trail[k][pend_a[k]] = pend_d[k];
        pend_v[k] = 1'b0;
        if (wr_en && !acc) begin
          ign_v[k] = 1'b1;
          ign_a[k] = wr_addr;
        end
        if (acc) begin
          m_lead[k][wr_addr] = wr_data;
          pend_v[k] = 1'b1;
          pend_a[k] = wr_addr;
          pend_d[k] = wr_data;
          if (ign_v[k] && ign_a[k] == wr_addr) ign_v[k] = 1'b0;
        end
        prev_acc[k] = acc;
        prev_a[k]   = wr_addr;
      end
      cyc++;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      for (int k = 0; k < 2; k++) begin
        if ((^exp_rd[k]) !== 1'bx)
          check(rd_o[k] === exp_rd[k], rd_tag[k], $sformatf("rd_data inst%0d", k),
                int'(rd_o[k]), int'(exp_rd[k]));
        check(slot_o[k] === ((cyc % 2) == int'(wp(k))), (cyc < 2) ? "R9" : "R2",
              $sformatf("wr_slot inst%0d", k), int'(slot_o[k]), int'((cyc % 2) == int'(wp(k))));
      end
      dbg_addr = AW'($urandom);
      #1;
      for (int k = 0; k < 2; k++) begin
        if ((^m_lead[k][dbg_addr]) !== 1'bx)
          check(lead_o[k] === m_lead[k][dbg_addr], "R8 R10", $sformatf("lead peek inst%0d", k),
                int'(lead_o[k]), int'(m_lead[k][dbg_addr]));
        if ((^m_trail[k][dbg_addr]) !== 1'bx)
          check(trail_o[k] === m_trail[k][dbg_addr], "R8 R10", $sformatf("trail peek inst%0d", k),
                int'(trail_o[k]), int'(m_trail[k][dbg_addr]));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state; R9: start phase
    for (int k = 0; k < 2; k++) begin
      check(rd_o[k] === '0, "R1", $sformatf("reset rd_data inst%0d", k), int'(rd_o[k]), 0);
      check(slot_o[k] === !wp(k), "R9", $sformatf("reset wr_slot inst%0d", k),
            int'(slot_o[k]), int'(!wp(k)));
    end
    rst_n = 1'b1;
    started = 1'b1;
    // preload every address in both instances
    for (int i = 0; i < 2 * DEPTH; i++) begin
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = AW'(i >> 1);
      wr_data = DW'((i >> 1) * 7 + 3);
      rd_addr = AW'($urandom);
    end
    // R3: writes alternate between slot and non-slot for each instance
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = AW'(5);
      wr_data = DW'(8'h90 + i);
      rd_addr = AW'(9);
    end
    @(negedge clk);
    wr_en = 1'b0;
    rd_addr = AW'(5);
    repeat (3) @(negedge clk);
    // R5/R6/R7: same-address reads while writing
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = AW'(2);
      wr_data = DW'(8'h40 + i * 3);
      rd_addr = AW'(2);
    end
    // random traffic concentrated on few addresses
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      wr_en   = 1'($urandom);
      wr_addr = AW'($urandom % 4);
      wr_data = DW'($urandom);
      rd_addr = ($urandom % 3 == 0) ? wr_addr : AW'($urandom % 4);
    end
    @(negedge clk);
    wr_en = 1'b0;
    repeat (4) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule